// File: doc/BRIEF.md
# Serial EEPROM Erase Command Controller

This block is the device side of a three-wire serial memory port, cut down to the two erase commands. A host frames a command by raising chip select and clocking bits in on the serial data line. Each bit is taken on a rising serial clock edge, most significant bit first. The block skips any leading zeros and treats the first 1 as the start bit. It then collects a 2-bit opcode and a 6-bit word address. Opcode 11 erases one word. Opcode 00, with the two top address bits equal to 10, erases every word. The remaining address bits of that command are ignored.

The erase runs on a timer clocked by the system clock. It begins on the system clock edge that sees the serial clock rise for the last address bit, and it needs no further serial clock edges. When the cycle ends, the target word, or the whole 64x16 array, becomes all ones. A host polls for completion by holding chip select low for a minimum time and then raising it. While the cycle runs, the data-out line then drives 0. Once the cycle is done it drives 1. Outside that window the output enable is low, so the line is released.

The serial inputs must already be synchronous to `clk_i`. A combinational read port lets neighbouring logic see the array contents.

Top module: `ee_erase_ctrl`

## Requirements
- R1: A frame of leading zeros, a start bit 1, opcode 11 and address bits MSB first erases only the addressed word to 16'hFFFF at the end of the cycle. Every other word keeps its contents.
- R2: Opcode 00 followed by address bits 5:4 equal to 2'b10 sets every word to 16'hFFFF at the end of the cycle. Address bits 3:0 are ignored.
- R3: Opcodes 01 and 10, and opcode 00 with address bits 5:4 other than 2'b10, change no word.
- R4: The cycle is busy from the system clock edge that samples the last address bit's serial clock rise. It stays busy for exactly CYC_LEN system clock cycles, with no further serial clock edges.
- R5: Chip select may be held low for at least TCSL_MIN system clocks and then raised while a cycle is busy. In that case `do_oe_o` goes to 1 with `do_o` 0. `do_o` turns to 1 once the cycle completes, while chip select stays high.
- R6: Raising chip select after fewer than TCSL_MIN low cycles leaves `do_oe_o` at 0.
- R7: `do_oe_o` is 0 on the cycle after chip select is seen low. A start bit received while ready also clears it.
- R8: A command framed while a cycle is busy is ignored in full, even if the cycle ends before the frame does.
- R9: Dropping chip select before the last address bit aborts the frame without changing the array.
- R10: After reset, word i holds the value i and `do_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock, sampled on clk_i |
| di_i | input | 1 | Serial data in |
| rd_addr_i | input | 6 | Array read address |
| do_o | output | 1 | Status: 0 busy, 1 ready |
| do_oe_o | output | 1 | Output enable for do_o |
| rd_data_o | output | 16 | Word at rd_addr_i |

## Verification
A frame decoder that slips a bit shows up as a different word turning to all ones, or as no erase at all. Either one is visible on the read port one cycle after the erase window closes. A timer loaded with the wrong length moves the cycle in which the polled status line turns from 0 to 1. The bench counts that cycle from the last address edge, so an off-by-one is caught. A status window that opens on a short low pulse, or stays open after chip select drops, appears on the output enable within one clock.

// File: rtl/ee_pkg.sv
package ee_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_OPC, RX_ADDR, RX_SKIP} rx_state_e;
  localparam logic [1:0] OP_ERASE = 2'b11;
  localparam logic [1:0] OP_MISC  = 2'b00;
  localparam logic [1:0] ALL_TAG  = 2'b10;
endpackage

// File: rtl/ee_frame_rx.sv
module ee_frame_rx
  import ee_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          sclk_rise_i,
  input  logic          di_i,
  input  logic          busy_i,
  output logic          start_seen_o,
  output logic          go_o,
  output logic          go_all_o,
  output logic [AW-1:0] go_addr_o
);
  localparam int CW = $clog2(AW + 1);
  localparam logic [CW-1:0] LAST = CW'(AW - 1);

  rx_state_e     st_q;
  logic [CW-1:0] cnt_q;
  logic [1:0]    op_q;
  logic [AW-1:0] addr_q;
  logic          shift, last;
  logic [AW-1:0] full_addr;

  assign shift        = sclk_rise_i & cs_i;
  assign full_addr    = {addr_q[AW-2:0], di_i};
  assign last         = shift && st_q == RX_ADDR && cnt_q == LAST;
  assign go_o         = last && op_q == OP_ERASE;
  assign go_all_o     = last && op_q == OP_MISC && full_addr[AW-1 -: 2] == ALL_TAG;
  assign go_addr_o    = full_addr;
  assign start_seen_o = shift && st_q == RX_IDLE && !busy_i && di_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      op_q   <= '0;
      addr_q <= '0;
    end else if (!cs_i) begin
      st_q <= RX_IDLE;
    end else if (shift) begin
      unique case (st_q)
        RX_IDLE: begin
          cnt_q <= '0;
          if (busy_i)    st_q <= RX_SKIP;
          else if (di_i) st_q <= RX_OPC;
        end
        RX_OPC: begin
          op_q  <= {op_q[0], di_i};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW'(1)) begin
            st_q  <= RX_ADDR;
            cnt_q <= '0;
          end
        end
        RX_ADDR: begin
          addr_q <= full_addr;
          cnt_q  <= cnt_q + 1'b1;
          if (cnt_q == LAST) st_q <= RX_SKIP;
        end
        default: st_q <= RX_SKIP;
      endcase
    end
  end

  // R8
  cmd_while_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_o || go_all_o) |-> !busy_i);
  // R3
  one_cmd_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({go_o, go_all_o}));
endmodule

// File: rtl/ee_cycle_timer.sv
module ee_cycle_timer #(
  parameter int CYC_LEN = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int TW = $clog2(CYC_LEN + 1);

  logic [TW-1:0] cnt_q;

  assign busy_o = cnt_q != '0;
  assign done_o = cnt_q == TW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (start_i)  cnt_q <= TW'(CYC_LEN);
    else if (busy_o)   cnt_q <= cnt_q - 1'b1;
  end

  // R4
  cycle_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o && cnt_q == TW'(CYC_LEN));
  // R4
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(done_o));
endmodule

// File: rtl/ee_word_array.sv
module ee_word_array #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          clr_all_i,
  input  logic [AW-1:0] clr_addr_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mem[i] <= DW'(i);
      else if (clr_all_i || (clr_i && clr_addr_i == AW'(i)))
        mem[i] <= '1;
    end
  end

  assign rd_data_o = mem[rd_addr_i];

  // R2
  clear_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_all_i |=> mem[0] == '1 && mem[DEPTH-1] == '1);
  // R1
  clear_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> mem[$past(clr_addr_i)] == '1);
endmodule

// File: rtl/ee_erase_ctrl.sv
module ee_erase_ctrl
  import ee_pkg::*;
#(
  parameter int AW       = 6,
  parameter int DW       = 16,
  parameter int CYC_LEN  = 40,
  parameter int TCSL_MIN = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          sclk_i,
  input  logic          di_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic          do_o,
  output logic          do_oe_o,
  output logic [DW-1:0] rd_data_o
);
  localparam int LW = $clog2(TCSL_MIN + 1);

  logic          cs_q, sclk_q, sclk_rise, cs_rise;
  logic          start_seen, go, go_all, busy, done;
  logic [AW-1:0] go_addr, addr_q;
  logic          all_q, win_q, csl_ok;
  logic [LW-1:0] low_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_i;
      sclk_q <= sclk_i;
    end
  end

  assign sclk_rise = sclk_i & ~sclk_q;
  assign cs_rise   = cs_i & ~cs_q;

  ee_frame_rx #(.AW(AW)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .sclk_rise_i(sclk_rise),
    .di_i(di_i), .busy_i(busy), .start_seen_o(start_seen), .go_o(go),
    .go_all_o(go_all), .go_addr_o(go_addr)
  );

  ee_cycle_timer #(.CYC_LEN(CYC_LEN)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(go | go_all),
    .busy_o(busy), .done_o(done)
  );

  // command latched for the whole cycle, applied at its end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      all_q  <= 1'b0;
      addr_q <= '0;
    end else if (go | go_all) begin
      all_q  <= go_all;
      addr_q <= go_addr;
    end
  end

  ee_word_array #(.AW(AW), .DW(DW)) u_arr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(done & ~all_q),
    .clr_all_i(done & all_q), .clr_addr_i(addr_q),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
  );

  // status window
  assign csl_ok = low_cnt_q == LW'(TCSL_MIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q <= '0;
      win_q     <= 1'b0;
    end else begin
      if (cs_i)         low_cnt_q <= '0;
      else if (!csl_ok) low_cnt_q <= low_cnt_q + 1'b1;
      if (!cs_i || start_seen)                     win_q <= 1'b0;
      else if (cs_rise && csl_ok && busy && !done) win_q <= 1'b1;
    end
  end

  assign do_oe_o = win_q;
  assign do_o    = win_q & ~busy;

  // R7
  oe_cs_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> !do_oe_o);
  // R5
  open_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(do_oe_o) |-> !do_o);
  // R6
  short_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise && !csl_ok) |=> !do_oe_o);
endmodule

// File: tb/sim_ee_erase_ctrl.sv
module sim_ee_erase_ctrl;
  localparam int CLK_P = 10;
  localparam int CYC   = 40;

  typedef struct {
    int          addr;
    logic [15:0] val;
    string       req;
  } sb_item_t;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sclk = 1'b0, di = 1'b0;
  logic [5:0]  rd_addr;
  logic        do_s, do_oe;
  logic [15:0] rd_data;
  logic [15:0] model [64];
  sb_item_t    sbq [$];
  logic        mon_act = 1'b0;
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  ee_erase_ctrl #(.CYC_LEN(CYC), .TCSL_MIN(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sclk_i(sclk), .di_i(di),
    .rd_addr_i(rd_addr), .do_o(do_s), .do_oe_o(do_oe), .rd_data_o(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic expect_word(input int a, input string req);
    sb_item_t it;
    it.addr = a; it.val = model[a]; it.req = req;
    sbq.push_back(it);
  endtask

  task automatic drain();
    do @(negedge clk); while (sbq.size() != 0 || mon_act);
  endtask

  // monitor: pops expected words and compares against the read port
  initial begin
    sb_item_t it;
    rd_addr = '0;
    forever begin
      @(negedge clk);
      while (sbq.size() != 0) begin
        mon_act = 1'b1;
        it = sbq.pop_front();
        rd_addr = 6'(it.addr);
        #1;
        chk(it.req, 32'(rd_data), 32'(it.val));
      end
      mon_act = 1'b0;
    end
  end

  task automatic send_bit(input logic b);
    @(negedge clk); sclk = 1'b0; di = b;
    @(negedge clk); sclk = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_frame(input int lead, input logic [1:0] op,
                            input logic [5:0] a, input int nbits);
    @(negedge clk); cs = 1'b1;
    repeat (lead) send_bit(1'b0);
    send_bit(1'b1);
    send_bit(op[1]); send_bit(op[0]);
    for (int i = 5; i > 5 - nbits; i--) send_bit(a[i]);
  endtask

  task automatic end_frame();
    @(negedge clk); sclk = 1'b0; cs = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog act=running exp=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int k;
    for (int i = 0; i < 64; i++) model[i] = 16'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 oe", 32'(do_oe), 0);
    expect_word(0, "R10"); expect_word(5, "R10"); expect_word(63, "R10");
    drain();

    // R1 R4 R5 word erase with leading zeros, polled status
    send_frame(2, 2'b11, 6'd5, 6);
    k = 1;
    end_frame(); k++;
    repeat (5) begin @(negedge clk); k++; end
    cs = 1'b1;
    @(negedge clk); k++;
    chk("R5 oe open", 32'(do_oe), 1);
    chk("R5 busy", 32'(do_s), 0);
    while (do_s == 1'b0 && k < 200) begin @(negedge clk); k++; end
    chk("R4 cycle length", 32'(k), 32'(CYC + 1));
    chk("R5 ready", 32'(do_s), 1);
    chk("R5 oe held", 32'(do_oe), 1);
    // R7 start bit while ready releases the line
    send_bit(1'b1);
    chk("R7 start bit", 32'(do_oe), 0);
    end_frame();
    @(negedge clk);
    model[5] = 16'hFFFF;
    expect_word(4, "R1"); expect_word(5, "R1"); expect_word(6, "R1");
    drain();

    // R8 frame during busy ignored
    send_frame(0, 2'b11, 6'd20, 6);
    end_frame();
    repeat (3) @(negedge clk);
    send_frame(0, 2'b11, 6'd21, 6);
    end_frame();
    repeat (CYC + 20) @(negedge clk);
    model[20] = 16'hFFFF;
    expect_word(20, "R8"); expect_word(21, "R8");
    drain();

    // R9 abort mid address
    send_frame(0, 2'b11, 6'b001010, 3);
    end_frame();
    repeat (CYC + 20) @(negedge clk);
    expect_word(10, "R9"); expect_word(11, "R9"); expect_word(8, "R9");
    drain();

    // R3 invalid commands
    send_frame(0, 2'b01, 6'd7, 6);  end_frame(); repeat (CYC + 10) @(negedge clk);
    send_frame(0, 2'b10, 6'd7, 6);  end_frame(); repeat (CYC + 10) @(negedge clk);
    send_frame(0, 2'b00, 6'b110111, 6); end_frame(); repeat (CYC + 10) @(negedge clk);
    send_frame(0, 2'b00, 6'b010111, 6); end_frame(); repeat (CYC + 10) @(negedge clk);
    expect_word(7, "R3"); expect_word(55, "R3"); expect_word(23, "R3");
    drain();

    // R6 short low pulse does not open the window
    send_frame(0, 2'b11, 6'd30, 6);
    end_frame();
    @(negedge clk);
    chk("R7 cs low", 32'(do_oe), 0);
    cs = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R6 short low", 32'(do_oe), 0);
    end
    cs = 1'b0;
    repeat (CYC + 10) @(negedge clk);
    model[30] = 16'hFFFF;
    expect_word(30, "R1");
    drain();

    // R2 erase all, low address bits don't care
    send_frame(0, 2'b00, 6'b100101, 6);
    end_frame();
    repeat (CYC + 10) @(negedge clk);
    for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
    expect_word(0, "R2"); expect_word(7, "R2"); expect_word(33, "R2");
    expect_word(55, "R2"); expect_word(63, "R2");
    drain();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule